// File: doc/BRIEF.md
# Write-Only Serial Command Receiver

This block is the target side of a two-wire serial bus (I2C) for a device that only ever takes commands. It recognises transfers sent to one fixed byte address, answers the address with an acknowledge, and then takes any number of command bytes until the controller ends the transfer. Each command byte it takes appears on a parallel output together with a strobe that lasts one cycle. Each such byte is also acknowledged on the bus.

The bus wires are sampled by a faster system clock. SDA is driven only as an open-drain pull-down enable. For a set number of system-clock cycles after reset, the receiver ignores the bus completely. This models the settling window after power-up, during which a controller must not talk to the device. Reads, clock stretching, general call and arbitration are not supported.

Top module: `i2c_wcmd_rx`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sda_pull_o` and `rx_valid_o` are both 0.
- R2: For the first `LOCKOUT_CYCLES` system-clock cycles after reset, no acknowledge is driven and no byte is strobed. A transfer already in progress when this window ends is also ignored, up to the next START.
- R3: An address byte equal to `DEV_ADDR` (default 0x88: the 7-bit address 1000100 followed by a write bit of 0) is acknowledged. SDA is pulled low from the SCL fall after the eighth bit, through the whole high phase of the ninth clock. It is released shortly after that clock falls.
- R4: An address byte of any other value, including 0x89 (read), is not acknowledged. The bytes that follow it are neither strobed nor acknowledged until the next START.
- R5: Each data byte is assembled MSB first from SDA sampled at SCL rising edges. It is presented on `rx_data_o` with `rx_valid_o` high for exactly one cycle, after the eighth bit and before the high phase of the acknowledge clock ends.
- R6: Every data byte after a matching address is acknowledged, with no limit on how many bytes one transfer carries.
- R7: A STOP (SDA rising while SCL is high) returns the receiver to idle. Clocked bits that follow without a START are neither acknowledged nor strobed.
- R8: A repeated START (SDA falling while SCL is high) in the middle of a transfer restarts address reception. The new address byte decides whether the bytes after it are accepted.
- R9: `sda_pull_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset; starts the lockout window |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire (includes this block's own pull-down) |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe marking a new `rx_data_o` |

## Verification
The end of the lockout window and an ongoing transfer can meet in the same stretch of cycles. The bench starts a write to the matching address straight after reset, so that the address acknowledge slot falls inside the window and the data byte's eighth bit falls after it. It judges the result at the pins: the address must go unacknowledged, the late data byte must produce neither a strobe nor an acknowledge, and a fresh START afterwards must be served normally. A repeated START placed right after an acknowledge, followed by a wrong address, is used in the same way to show that the START overrides byte reception.

// File: rtl/i2c_wcmd_rx.sv
module i2c_wcmd_rx #(
  parameter int         LOCKOUT_CYCLES = 2_500_000,
  parameter logic [7:0] DEV_ADDR       = 8'h88
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o
);

  localparam int LW = (LOCKOUT_CYCLES > 0) ? $clog2(LOCKOUT_CYCLES + 1) : 1;
  localparam logic [LW-1:0] LOCK_END = LW'(LOCKOUT_CYCLES);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_WAIT_ACK, S_ACK} st_t;

  logic [LW-1:0] lock_cnt;
  logic [2:0]    scl_q, sda_q;
  logic [7:0]    sh;
  logic [2:0]    bit_cnt;
  logic          ack_hi;
  st_t           state;

  wire locked   = lock_cnt != LOCK_END;
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire scl_held = scl_q[1] & scl_q[2];
  wire start_d  = scl_held & ~sda_q[1] & sda_q[2];
  wire stop_d   = scl_held & sda_q[1] & ~sda_q[2];
  wire [7:0] nxt_byte = {sh[6:0], sda_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock_cnt <= '0;
    else if (locked) lock_cnt <= lock_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      sh         <= '0;
      bit_cnt    <= '0;
      ack_hi     <= 1'b0;
      sda_pull_o <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (locked) begin
        state      <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_d) begin
        state      <= S_ADDR;
        bit_cnt    <= '0;
        ack_hi     <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (stop_d) begin
        state      <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_DATA:
            if (scl_rise) begin
              sh      <= nxt_byte;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (state == S_ADDR) begin
                  state <= (nxt_byte == DEV_ADDR) ? S_WAIT_ACK : S_IDLE;
                end else begin
                  rx_data_o  <= nxt_byte;
                  rx_valid_o <= 1'b1;
                  state      <= S_WAIT_ACK;
                end
              end
            end
          S_WAIT_ACK:
            if (scl_fall) begin
              state      <= S_ACK;
              sda_pull_o <= 1'b1;
              ack_hi     <= 1'b0;
            end
          S_ACK:
            if (scl_rise) begin
              ack_hi <= 1'b1;
            end else if (scl_fall && ack_hi) begin
              sda_pull_o <= 1'b0;
              state      <= S_DATA;
              bit_cnt    <= '0;
            end
          default: ;
        endcase
      end
    end
  end

  p_quiet_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!sda_pull_o && !rx_valid_o));

  p_ack_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(state == S_WAIT_ACK));

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_d && !start_d && !locked) |=> (state == S_IDLE && !sda_pull_o));

  p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_q[1]));

endmodule

// File: tb/i2c_wcmd_rx_tb.sv
module i2c_wcmd_rx_tb;
  localparam int LOCK = 700;
  localparam int HALF = 20;
  localparam int NV   = 6;
  // {address, data0, data1, accepted}
  localparam logic [24:0] VEC [NV] = '{
    {8'h88, 8'hA5, 8'h3C, 1'b1},
    {8'h88, 8'h00, 8'hFF, 1'b1},
    {8'h89, 8'h12, 8'h34, 1'b0},
    {8'h8A, 8'h56, 8'h78, 1'b0},
    {8'h08, 8'h9A, 8'hBC, 1'b0},
    {8'h88, 8'h80, 8'h01, 1'b1}
  };

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic sda_pull_o, rx_valid_o;
  logic [7:0] rx_data_o;
  wire sda_line = sda_m & ~sda_pull_o;
  int n_chk = 0, n_fail = 0, rx_cnt = 0;
  logic [7:0] rx_log [64];

  always #10 clk = ~clk;

  i2c_wcmd_rx #(.LOCKOUT_CYCLES(LOCK), .DEV_ADDR(8'h88)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o));

  always @(negedge clk) if (rx_valid_o) begin
    rx_log[rx_cnt % 64] = rx_data_o;
    rx_cnt = rx_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1; wt(HALF); scl = 1; wt(HALF); sda_m = 0; wt(HALF); scl = 0; wt(HALF);
  endtask

  task automatic bus_stop;
    sda_m = 0; wt(HALF); scl = 1; wt(HALF); sda_m = 1; wt(HALF);
  endtask

  // acked: line low at both samples of the ninth high phase; rel: line high after it
  task automatic send_byte(input logic [7:0] b, output bit acked, output bit rel, output int strobes);
    int c0 = rx_cnt;
    bit a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HALF); scl = 1; wt(HALF); scl = 0;
    end
    sda_m = 1; wt(HALF); scl = 1; wt(HALF / 2);
    a1 = !sda_line;
    strobes = rx_cnt - c0;
    wt(HALF / 2);
    a2 = !sda_line;
    scl = 0; wt(6);
    rel = sda_line;
    acked = a1 && a2;
  endtask

  initial begin
    bit ak, rl;
    int st, base;
    wt(3);
    chk(sda_pull_o == 0 && rx_valid_o == 0, "R1 reset", {sda_pull_o, rx_valid_o}, 0);
    rst_n = 1;
    wt(1);
    chk(sda_pull_o == 0 && rx_valid_o == 0, "R1 after reset", {sda_pull_o, rx_valid_o}, 0);

    // R2: address inside the lockout, data byte ends after it
    bus_start();
    send_byte(8'h88, ak, rl, st);
    chk(!ak, "R2 no ack in lockout", ak, 0);
    send_byte(8'hAB, ak, rl, st);
    chk(!ak && rx_cnt == 0, "R2 late byte ignored", rx_cnt, 0);
    bus_stop();
    wt(50);

    // table of transfers (R3, R4, R5, R6)
    for (int v = 0; v < NV; v++) begin
      base = rx_cnt;
      bus_start();
      send_byte(VEC[v][24:17], ak, rl, st);
      chk(ak == VEC[v][0], "R3/R4 address ack", ak, VEC[v][0]);
      chk(rl, "R3 release after ack", rl, 1);
      send_byte(VEC[v][16:9], ak, rl, st);
      chk(ak == VEC[v][0], "R6 data ack", ak, VEC[v][0]);
      chk(st == (VEC[v][0] ? 1 : 0), "R5 strobe before ack end", st, VEC[v][0]);
      send_byte(VEC[v][8:1], ak, rl, st);
      chk(ak == VEC[v][0], "R6 second data ack", ak, VEC[v][0]);
      bus_stop();
      if (VEC[v][0]) begin
        chk(rx_cnt == base + 2, "R5 byte count", rx_cnt - base, 2);
        chk(rx_log[base % 64] == VEC[v][16:9], "R5 first byte", rx_log[base % 64], VEC[v][16:9]);
        chk(rx_log[(base + 1) % 64] == VEC[v][8:1], "R5 second byte", rx_log[(base + 1) % 64], VEC[v][8:1]);
      end else begin
        chk(rx_cnt == base, "R4 nothing strobed", rx_cnt - base, 0);
      end
      wt(20);
    end

    // R6: long stream
    base = rx_cnt;
    bus_start();
    send_byte(8'h88, ak, rl, st);
    for (int k = 0; k < 20; k++) begin
      send_byte(8'(k * 13 + 7), ak, rl, st);
      chk(ak, "R6 stream ack", ak, 1);
      chk(rx_log[(base + k) % 64] == 8'(k * 13 + 7), "R6 stream byte", rx_log[(base + k) % 64], 8'(k * 13 + 7));
    end
    bus_stop();

    // R8: repeated start, good then bad address
    base = rx_cnt;
    bus_start();
    send_byte(8'h88, ak, rl, st);
    send_byte(8'h11, ak, rl, st);
    bus_start();
    send_byte(8'h88, ak, rl, st);
    chk(ak, "R8 restart address ack", ak, 1);
    send_byte(8'h22, ak, rl, st);
    chk(rx_cnt == base + 2 && rx_log[(base + 1) % 64] == 8'h22, "R8 restart data", rx_log[(base + 1) % 64], 8'h22);
    bus_start();
    send_byte(8'h90, ak, rl, st);
    chk(!ak, "R8 restart bad address", ak, 0);
    send_byte(8'h33, ak, rl, st);
    chk(!ak && rx_cnt == base + 2, "R8 ignored after bad restart", rx_cnt - base, 2);
    bus_stop();

    // R7: bits after STOP without START
    base = rx_cnt;
    bus_start();
    send_byte(8'h88, ak, rl, st);
    send_byte(8'h66, ak, rl, st);
    bus_stop();
    scl = 0; wt(HALF);
    send_byte(8'h77, ak, rl, st);
    chk(!ak, "R7 no ack after stop", ak, 0);
    chk(rx_cnt == base + 1, "R7 no strobe after stop", rx_cnt - base, 1);
    scl = 1; wt(HALF);

    // R9: a fresh transfer is still served
    bus_start();
    send_byte(8'h88, ak, rl, st);
    chk(ak && rl, "R9 ack driven and released", {ak, rl}, 3);
    bus_stop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule